// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank synchronous DRAM interface. On every rising clock edge it samples the chip select, the three command strobes, the two bank-select bits and the 11-bit address. It classifies the cycle as one of several command types and emits a one-cycle registered strobe for each accepted command. It also tracks which banks hold an open row and which row that is.

Commands are gated by the clock enable from the previous edge. The address bit at position 10 is read as an all-banks flag on precharge and as an auto-precharge flag on a column access. A column access to an idle bank, or an activate to a bank that is already open, is reported as an error and otherwise ignored. A registered low-power flag shows when the clock enable is low while every bank is idle.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n_i` high at an enabled edge, no command strobe rises and the bank state, rows and latched fields are unchanged.
- R2: With `cs_n_i` low, the pattern {ras,cas,we} decodes as follows: 011 activate, 010 precharge, 101 read, 100 write, 001 auto refresh, 000 mode register set, 110 burst stop, 111 no-op. Each accepted command raises its strobe for exactly the one cycle after the sampling edge, and at most one of act, pre, rd, wr, ref, bst, mrs and err is high in any cycle.
- R3: A precharge with address bit 10 low returns only the bank given by `ba_i` to idle. It latches that bank into `cmd_bank_o`.
- R4: An activate to an idle bank marks that bank active, stores all 11 address bits as its open row, and latches the bank into `cmd_bank_o`.
- R5: A read or write to an active bank latches address bits 7:0 into `col_o`, bit 10 into `auto_pre_o` and the bank into `cmd_bank_o`. When bit 10 is high, the bank returns to idle at the same edge.
- R6: A precharge with address bit 10 high returns all four banks to idle and raises `pre_all_o` together with `pre_o`.
- R7: A read or write to an idle bank, or an activate to an active bank, raises `err_o` for one cycle. No other strobe rises and no state or latched field changes.
- R8: When `cke_i` is sampled low at edge N, the command at edge N+1 is ignored: no strobe rises and all state holds. Decoding resumes one edge after `cke_i` is sampled high again.
- R9: `pd_o` is high in the cycle after an edge at which `cke_i` is low and every bank is idle after that edge's update. Otherwise it is low.
- R10: During reset all strobes and `pd_o` are low, all banks are idle, rows, column, bank and auto-precharge fields are zero, and the clock enable is treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable, governs the next edge |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 11 | Address / flag bits |
| act_o | output | 1 | Activate accepted |
| pre_o | output | 1 | Precharge accepted |
| pre_all_o | output | 1 | Precharge applied to all banks |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| ref_o | output | 1 | Auto refresh |
| bst_o | output | 1 | Burst stop |
| mrs_o | output | 1 | Mode register set |
| err_o | output | 1 | Illegal command for the bank state |
| cmd_bank_o | output | 2 | Bank of last accepted banked command |
| col_o | output | 8 | Column of last accepted access |
| auto_pre_o | output | 1 | Auto-precharge flag of last access |
| bank_active_o | output | 4 | Per-bank active flags |
| open_row_o | output | 44 | Open row per bank, bank b at bits b*11 +: 11 |
| pd_o | output | 1 | Low-power entry condition met |

## Verification
Every result is registered once, so a command sampled at one rising edge shows on the outputs from that edge until the next one. The bench drives inputs on the falling edge, lets one rising edge pass, and compares at the following falling edge against a model stepped once per drive. The clock-enable effect lags by one more edge: the model keeps its own copy of the previous enable and applies it to the next command, so a low enable blocks the command one cycle later. The low-power flag uses the current enable together with the bank state after that edge, and is checked in the same cycle as the strobes.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_PRE,
    CMD_RD,
    CMD_WR,
    CMD_REF,
    CMD_MRS,
    CMD_BST
  } cmd_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n_i) begin
      cmd_o = CMD_DESEL;                       // R1
    end else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})  // R2
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = CMD_PRE;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_nxt_o,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_nxt;

  always_comb begin
    active_nxt_o = active_o;
    row_nxt      = row_o;
    if (en_i) begin
      if (open_i) begin
        active_nxt_o = 1'b1;
        row_nxt      = row_i;
      end else if (close_i) begin
        active_nxt_o = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      row_o    <= '0;
    end else if (en_i) begin
      active_o <= active_nxt_o;
      row_o    <= row_nxt;
    end
  end

  AST_OPEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && open_i) |=> (active_o && row_o == $past(row_i)));  // R4
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke_i,
  input  logic                   cs_n_i,
  input  logic                   ras_n_i,
  input  logic                   cas_n_i,
  input  logic                   we_n_i,
  input  logic [1:0]             ba_i,
  input  logic [ROW_W-1:0]       addr_i,
  output logic                   act_o,
  output logic                   pre_o,
  output logic                   pre_all_o,
  output logic                   rd_o,
  output logic                   wr_o,
  output logic                   ref_o,
  output logic                   bst_o,
  output logic                   mrs_o,
  output logic                   err_o,
  output logic [1:0]             cmd_bank_o,
  output logic [COL_W-1:0]       col_o,
  output logic                   auto_pre_o,
  output logic [BANKS-1:0]       bank_active_o,
  output logic [BANKS*ROW_W-1:0] open_row_o,
  output logic                   pd_o
);
  localparam int BA_W = $clog2(BANKS);

  cmd_e             cmd;
  logic             cke_q;
  logic             en;
  logic             sel_act;
  logic             is_col;
  logic             ap_bit;
  logic             acc_act, acc_pre, acc_rd, acc_wr, bad_cmd;
  logic [BANKS-1:0] open_v, close_v, act_nxt;
  logic             pd_nxt;
  logic             latch_bank, latch_col;

  sdcmd_decode u_decode (
    .cs_n_i  (cs_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .cmd_o   (cmd)
  );

  // decode is enabled by the clock enable seen one edge earlier (R8)
  assign en      = cke_q;
  assign sel_act = bank_active_o[ba_i[BA_W-1:0]];
  assign is_col  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign ap_bit  = addr_i[AP_BIT];

  always_comb begin
    acc_act = en && (cmd == CMD_ACT) && !sel_act;
    acc_pre = en && (cmd == CMD_PRE);
    acc_rd  = en && (cmd == CMD_RD) && sel_act;
    acc_wr  = en && (cmd == CMD_WR) && sel_act;
    bad_cmd = en && (((cmd == CMD_ACT) && sel_act) || (is_col && !sel_act));
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit        = (ba_i[BA_W-1:0] == BA_W'(b));
    assign open_v[b]  = acc_act && hit;
    assign close_v[b] = (acc_pre && (ap_bit || hit))
                      || ((acc_rd || acc_wr) && ap_bit && hit);
    sdcmd_bank #(.ROW_W(ROW_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en),
      .open_i       (open_v[b]),
      .close_i      (close_v[b]),
      .row_i        (addr_i),
      .active_nxt_o (act_nxt[b]),
      .active_o     (bank_active_o[b]),
      .row_o        (open_row_o[b*ROW_W +: ROW_W])
    );
  end

  assign pd_nxt     = !cke_i && (act_nxt == '0);
  assign latch_bank = acc_act || acc_pre || acc_rd || acc_wr;
  assign latch_col  = acc_rd || acc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      act_o     <= 1'b0;
      pre_o     <= 1'b0;
      pre_all_o <= 1'b0;
      rd_o      <= 1'b0;
      wr_o      <= 1'b0;
      ref_o     <= 1'b0;
      bst_o     <= 1'b0;
      mrs_o     <= 1'b0;
      err_o     <= 1'b0;
      pd_o      <= 1'b0;
    end else begin
      cke_q     <= cke_i;
      act_o     <= acc_act;
      pre_o     <= acc_pre;
      pre_all_o <= acc_pre && ap_bit;
      rd_o      <= acc_rd;
      wr_o      <= acc_wr;
      ref_o     <= en && (cmd == CMD_REF);
      bst_o     <= en && (cmd == CMD_BST);
      mrs_o     <= en && (cmd == CMD_MRS);
      err_o     <= bad_cmd;
      pd_o      <= pd_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_bank_o <= '0;
    end else if (latch_bank) begin
      cmd_bank_o <= ba_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_o      <= '0;
      auto_pre_o <= 1'b0;
    end else if (latch_col) begin
      col_o      <= addr_i[COL_W-1:0];
      auto_pre_o <= ap_bit;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_o, pre_o, rd_o, wr_o, ref_o, bst_o, mrs_o, err_o}));  // R2
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> ($stable(bank_active_o) && !act_o && !pre_o && !rd_o && !wr_o && !err_o));  // R1
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> bank_active_o[cmd_bank_o]);  // R4
  AST_COL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_o || wr_o) && !auto_pre_o) |-> bank_active_o[cmd_bank_o]);  // R5
  AST_PRE_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_o |-> (bank_active_o == '0));  // R6
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(bank_active_o) && $stable(open_row_o)));  // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> ($stable(bank_active_o) && $stable(open_row_o) && !act_o && !err_o));  // R8
  AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pd_o |-> (bank_active_o == '0));  // R9
endmodule

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [10:0] addr;
  logic        act, pre, pall, rd, wr, rf, bst, mrs, err, ap, pd;
  logic [1:0]  cbank;
  logic [7:0]  col;
  logic [3:0]  bact;
  logic [43:0] rows;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model state
  logic [3:0]  m_act;
  logic [43:0] m_row;
  logic [1:0]  m_bank;
  logic [7:0]  m_col;
  logic        m_ap, m_cke, m_pd;
  logic [8:0]  m_str;
  string       m_tag;

  always #5 clk = ~clk;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
    .act_o(act), .pre_o(pre), .pre_all_o(pall), .rd_o(rd), .wr_o(wr),
    .ref_o(rf), .bst_o(bst), .mrs_o(mrs), .err_o(err), .cmd_bank_o(cbank),
    .col_o(col), .auto_pre_o(ap), .bank_active_o(bact), .open_row_o(rows),
    .pd_o(pd)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // expected strobes {act,pre,pall,rd,wr,ref,bst,mrs,err}
  function automatic logic [8:0] strobe(input int k);
    return 9'b1 << (8 - k);
  endfunction

  task automatic model(input logic c_cke, input logic c_cs, input logic [2:0] rcw,
                       input logic [1:0] c_ba, input logic [10:0] a);
    m_str = '0;
    m_tag = "R2";
    if (!m_cke) begin
      m_tag = "R8";
    end else if (c_cs) begin
      m_tag = "R1";
    end else begin
      case (rcw)
        3'b011: if (m_act[c_ba]) begin m_str = strobe(8); m_tag = "R7"; end
                else begin
                  m_str = strobe(0); m_act[c_ba] = 1'b1;
                  m_row[c_ba*11 +: 11] = a; m_bank = c_ba; m_tag = "R4";
                end
        3'b010: begin
                  m_bank = c_ba;
                  if (a[10]) begin m_str = strobe(1) | strobe(2); m_act = '0; m_tag = "R6"; end
                  else begin m_str = strobe(1); m_act[c_ba] = 1'b0; m_tag = "R3"; end
                end
        3'b101, 3'b100:
                if (!m_act[c_ba]) begin m_str = strobe(8); m_tag = "R7"; end
                else begin
                  m_str = (rcw == 3'b101) ? strobe(3) : strobe(4);
                  m_bank = c_ba; m_col = a[7:0]; m_ap = a[10];
                  if (a[10]) m_act[c_ba] = 1'b0;
                  m_tag = "R5";
                end
        3'b001: m_str = strobe(5);
        3'b110: m_str = strobe(6);
        3'b000: m_str = strobe(7);
        default: m_str = '0;
      endcase
    end
    m_cke = c_cke;
    m_pd  = !c_cke && (m_act == '0);
  endtask

  task automatic compare();
    chk(m_tag, "strobes", {55'd0, act, pre, pall, rd, wr, rf, bst, mrs, err}, {55'd0, m_str});
    chk(m_tag, "bank_active", {60'd0, bact}, {60'd0, m_act});
    chk(m_tag, "open_row", {20'd0, rows}, {20'd0, m_row});
    chk(m_tag, "cmd_bank/col/ap", {53'd0, cbank, col, ap}, {53'd0, m_bank, m_col, m_ap});
    chk("R9", "pd", {63'd0, pd}, {63'd0, m_pd});
  endtask

  // drive on the falling edge, check at the next falling edge
  task automatic step(input logic c_cke, input logic c_cs, input logic [2:0] rcw,
                      input logic [1:0] c_ba, input logic [10:0] a);
    cke = c_cke; cs_n = c_cs; {ras_n, cas_n, we_n} = rcw; ba = c_ba; addr = a;
    model(c_cke, c_cs, rcw, c_ba, a);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  localparam logic [2:0] C_ACT = 3'b011, C_PRE = 3'b010, C_RD = 3'b101,
                         C_WR = 3'b100, C_NOP = 3'b111;

  initial begin
    #(64'd200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
    ba = '0; addr = '0;
    m_act = '0; m_row = '0; m_bank = '0; m_col = '0; m_ap = 1'b0;
    m_cke = 1'b1; m_pd = 1'b0; m_str = '0; m_tag = "R10";
    repeat (3) @(negedge clk);
    compare();                                       // R10 reset state
    chk("R10", "reset strobes", {55'd0, act, pre, pall, rd, wr, rf, bst, mrs, err}, 64'd0);
    rst_n = 1'b1;

    step(1, 0, C_ACT, 2'd2, 11'h7FF);                // R4 activate, full row
    step(1, 0, C_RD,  2'd2, 11'h0FF);                // R5 read, top column
    step(1, 0, C_RD,  2'd1, 11'h010);                // R7 read to idle bank
    step(1, 0, C_ACT, 2'd2, 11'h001);                // R7 activate to open bank
    step(1, 1, C_ACT, 2'd0, 11'h123);                // R1 deselect
    step(1, 0, C_ACT, 2'd0, 11'h400);                // R4
    step(0, 0, C_NOP, 2'd0, 11'h000);                // cke low sampled
    step(1, 0, C_ACT, 2'd3, 11'h055);                // R8 ignored
    step(1, 0, C_ACT, 2'd3, 11'h055);                // R4 accepted
    step(1, 0, C_WR,  2'd3, 11'h4AA);                // R5 write with auto precharge
    step(1, 0, C_PRE, 2'd0, 11'h000);                // R3 single-bank precharge
    step(1, 0, 3'b001, 2'd0, 11'h000);               // R2 refresh
    step(1, 0, 3'b000, 2'd0, 11'h033);               // R2 mode set
    step(1, 0, 3'b110, 2'd0, 11'h000);               // R2 burst stop
    step(1, 0, C_ACT, 2'd1, 11'h2C3);
    step(1, 0, C_PRE, 2'd3, 11'h400);                // R6 all-bank precharge
    step(0, 0, C_NOP, 2'd0, 11'h000);                // R9 idle + cke low
    step(0, 0, C_ACT, 2'd1, 11'h111);                // R8 frozen, R9 stays
    step(1, 0, C_NOP, 2'd0, 11'h000);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(15));
      step(($urandom_range(9) != 0), (r == 4'd0), 3'($urandom_range(7)),
           2'($urandom_range(3)), 11'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule